// File: doc/BRIEF.md
# Single-Butterfly Folded Radix-4 Stage Sequencer

This block holds a bank of 64 complex samples and transforms it with three radix-4 stages, all carried out by one shared four-input butterfly. A 6-bit micro-step counter drives the work: its upper two bits select the stage and its lower four bits select which group of four neighbouring elements the butterfly rewrites in that cycle. On the last group of each stage, the whole bank is reordered by a fixed base-4 digit-reversal permutation in the same clock edge as the butterfly write. A complete block therefore takes 48 cycles.

The bank is filled one element at a time through a load port while the block is idle. A start pulse begins the 48 micro-steps. When they finish, `done` rises and stays high, and the result is read through a combinational read port. The butterfly is a placeholder network. It applies quarter-turn rotations as twiddles and uses wrapping two's-complement arithmetic with no scaling.

Top module: `sfb_core`

## Requirements
- R1: While `rst_n` is low and after its release, `busy` and `done` are 0 until a start is accepted.
- R2: When `load_en` is high and `busy` is low, the element at `load_idx` takes `{load_re, load_im}` at the clock edge. `rd_re`/`rd_im` always show the element at `rd_idx` combinationally.
- R3: A start accepted while idle makes `busy` high for exactly 48 cycles. At the edge of the 48th micro-step `busy` falls and `done` rises. `done` stays high until the next accepted load or start.
- R4: Micro-step with step index k rewrites only elements 4k..4k+3. On steps 0..14 every other element keeps its value.
- R5: The butterfly takes inputs x0..x3 and a twiddle code t. First xn is rotated by (n*t mod 4) quarter turns. Then output m is the wrapping sum over n of xn rotated by (m*n mod 4) quarter turns. Rotation code 0 keeps (re,im); code 1 gives (im,-re); code 2 gives (-re,-im); code 3 gives (-im,re). All arithmetic is modulo 2^DW.
- R6: The twiddle code depends on stage s and step k as follows: s=0 gives 0; s=1 gives k mod 4; s=2 gives (k mod 4) XOR (k div 4).
- R7: On the micro-step with step index 15, after the butterfly write, new element i takes the value of element r(i) in the same edge. Here r swaps the base-4 digits of the 6-bit index: bits [1:0] become [5:4], bits [3:2] stay, and bits [5:4] become [1:0].
- R8: While `busy` is high, `load_en` and `start` have no effect on the bank or the sequence.
- R9: The counter splits into stage = count div 16 and step = count mod 16. It counts 0..47 and returns to 0 at the end, so further blocks can be loaded and run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_en | input | 1 | Write one bank element (idle only) |
| load_idx | input | 6 | Element index for the write |
| load_re | input | DW | Real part to write |
| load_im | input | DW | Imaginary part to write |
| start | input | 1 | Begin the 48 micro-steps (idle only) |
| rd_idx | input | 6 | Element index to read |
| rd_re | output | DW | Real part of element `rd_idx` |
| rd_im | output | DW | Imaginary part of element `rd_idx` |
| busy | output | 1 | Micro-steps in progress |
| done | output | 1 | Result ready in the bank |

## Verification
The bench builds the block with DW=6. At that width, random full-range samples make the four-term butterfly sums wrap often, so the modular arithmetic and the sign handling of the rotations are exercised in almost every micro-step. The narrow width also makes the impulse and all-ones corner blocks produce results that are easy to tell apart across the three twiddle rules. Several blocks are run back to back to reach the counter wrap, and one run has load and start pulses injected while it is busy.

// File: rtl/sfb_pkg.sv
package sfb_pkg;
  localparam int BANK_N  = 64;
  localparam int GRP     = 4;
  localparam int STEPS   = BANK_N / GRP;
  localparam int STAGES  = 3;
  localparam int TOTAL   = STEPS * STAGES;
  localparam int IDX_W   = $clog2(BANK_N);
  localparam int STEP_W  = $clog2(STEPS);
  localparam int CNT_W   = IDX_W;
  localparam int STAGE_W = CNT_W - STEP_W;

  typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} run_e;

  // base-4 digit reversal of a 6-bit element index
  function automatic logic [IDX_W-1:0] digit_rev(input logic [IDX_W-1:0] i);
    return {i[1:0], i[3:2], i[5:4]};
  endfunction
endpackage

// File: rtl/sfb_twiddle.sv
module sfb_twiddle
  import sfb_pkg::*;
(
  input  logic [STAGE_W-1:0] stage,
  input  logic [STEP_W-1:0]  step,
  output logic [1:0]         tw
);
  always_comb begin
    case (stage)
      2'd1:    tw = step[1:0];
      2'd2:    tw = step[1:0] ^ step[3:2];
      default: tw = 2'd0;
    endcase
  end
endmodule

// File: rtl/sfb_bfly4.sv
module sfb_bfly4
  import sfb_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [GRP-1:0][DW-1:0] x_re,
  input  logic [GRP-1:0][DW-1:0] x_im,
  input  logic [1:0]             tw,
  output logic [GRP-1:0][DW-1:0] y_re,
  output logic [GRP-1:0][DW-1:0] y_im
);
  function automatic logic [2*DW-1:0] rot(input logic [DW-1:0] a,
                                          input logic [DW-1:0] b,
                                          input logic [1:0]    k);
    case (k)
      2'd1:    return {b, DW'(-a)};
      2'd2:    return {DW'(-a), DW'(-b)};
      2'd3:    return {DW'(-b), a};
      default: return {a, b};
    endcase
  endfunction

  logic [GRP-1:0][DW-1:0] r_re, r_im;

  always_comb begin
    for (int n = 0; n < GRP; n++) begin
      {r_re[n], r_im[n]} = rot(x_re[n], x_im[n], 2'(n * int'(tw)));
    end
  end

  always_comb begin
    logic [DW-1:0] acc_re, acc_im, t_re, t_im;
    for (int m = 0; m < GRP; m++) begin
      acc_re = '0;
      acc_im = '0;
      for (int n = 0; n < GRP; n++) begin
        {t_re, t_im} = rot(r_re[n], r_im[n], 2'(m * n));
        acc_re = acc_re + t_re;
        acc_im = acc_im + t_im;
      end
      y_re[m] = acc_re;
      y_im[m] = acc_im;
    end
  end
endmodule

// File: rtl/sfb_ctrl.sv
module sfb_ctrl
  import sfb_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               load_en,
  output logic               busy,
  output logic               done,
  output logic               last_step,
  output logic [STAGE_W-1:0] stage,
  output logic [STEP_W-1:0]  step
);
  run_e             st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             done_q, done_d;
  logic             cnt_en;

  assign busy      = (st_q == ST_RUN);
  assign done      = done_q;
  assign stage     = cnt_q[CNT_W-1:STEP_W];
  assign step      = cnt_q[STEP_W-1:0];
  assign last_step = busy && (cnt_q == CNT_W'(TOTAL - 1));
  assign cnt_en    = busy;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    done_d = done_q;
    if (st_q == ST_RUN) begin
      if (last_step) begin
        st_d   = ST_IDLE;
        cnt_d  = '0;
        done_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end else if (start) begin
      st_d   = ST_RUN;
      cnt_d  = '0;
      done_d = 1'b0;
    end else if (load_en) begin
      done_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en || start) cnt_q <= cnt_d;
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CNT_W'(TOTAL)); // R9
  AST_RUN_END: assert property (@(posedge clk) disable iff (!rst_n)
    last_step |=> (done && !busy && cnt_q == '0)); // R3
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R3
  AST_RUN_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last_step) |=> (busy && cnt_q == CNT_W'($past(cnt_q) + 1'b1))); // R8
endmodule

// File: rtl/sfb_core.sv
module sfb_core
  import sfb_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic [IDX_W-1:0] load_idx,
  input  logic [DW-1:0]    load_re,
  input  logic [DW-1:0]    load_im,
  input  logic             start,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [DW-1:0]    rd_re,
  output logic [DW-1:0]    rd_im,
  output logic             busy,
  output logic             done
);
  logic [DW-1:0] re_q [BANK_N];
  logic [DW-1:0] im_q [BANK_N];
  logic [DW-1:0] re_d [BANK_N];
  logic [DW-1:0] im_d [BANK_N];
  logic [DW-1:0] wr_re [BANK_N];
  logic [DW-1:0] wr_im [BANK_N];

  logic [STAGE_W-1:0]     stage;
  logic [STEP_W-1:0]      step;
  logic                   last_step;
  logic [1:0]             tw;
  logic [GRP-1:0][DW-1:0] bf_in_re, bf_in_im, bf_out_re, bf_out_im;
  logic                   load_ok, bank_en, perm_now;

  sfb_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .load_en   (load_en),
    .busy      (busy),
    .done      (done),
    .last_step (last_step),
    .stage     (stage),
    .step      (step)
  );

  sfb_twiddle u_tw (
    .stage (stage),
    .step  (step),
    .tw    (tw)
  );

  sfb_bfly4 #(.DW(DW)) u_bfly (
    .x_re (bf_in_re),
    .x_im (bf_in_im),
    .tw   (tw),
    .y_re (bf_out_re),
    .y_im (bf_out_im)
  );

  assign load_ok  = load_en && !busy;
  assign bank_en  = busy || load_ok;
  assign perm_now = busy && (step == STEP_W'(STEPS - 1));
  assign rd_re    = re_q[rd_idx];
  assign rd_im    = im_q[rd_idx];

  // operand fetch for the current group of four
  always_comb begin
    for (int n = 0; n < GRP; n++) begin
      bf_in_re[n] = re_q[GRP * int'(step) + n];
      bf_in_im[n] = im_q[GRP * int'(step) + n];
    end
  end

  // butterfly write-back into its window
  always_comb begin
    wr_re = re_q;
    wr_im = im_q;
    if (busy) begin
      for (int n = 0; n < GRP; n++) begin
        wr_re[GRP * int'(step) + n] = bf_out_re[n];
        wr_im[GRP * int'(step) + n] = bf_out_im[n];
      end
    end
  end

  // end-of-stage reorder, then idle load
  always_comb begin
    re_d = wr_re;
    im_d = wr_im;
    if (perm_now) begin
      for (int i = 0; i < BANK_N; i++) begin
        re_d[i] = wr_re[digit_rev(IDX_W'(i))];
        im_d[i] = wr_im[digit_rev(IDX_W'(i))];
      end
    end
    if (load_ok) begin
      re_d[load_idx] = load_re;
      im_d[load_idx] = load_im;
    end
  end

  always_ff @(posedge clk) begin
    if (bank_en) begin
      re_q <= re_d;
      im_q <= im_d;
    end
  end

  for (genvar g = 0; g < BANK_N; g++) begin : g_win_chk
    AST_WINDOW_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !perm_now && (int'(step) != g / GRP))
        |=> ($stable(re_q[g]) && $stable(im_q[g]))); // R4
  end
endmodule

// File: tb/sim_sfb_core.sv
`timescale 1ns/1ps
module sim_sfb_core;
  localparam int DW = 6;
  localparam int N  = 64;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          load_en, start;
  logic [5:0]    load_idx, rd_idx;
  logic [DW-1:0] load_re, load_im, rd_re, rd_im;
  logic          busy, done;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;

  logic [DW-1:0] m_re [N];
  logic [DW-1:0] m_im [N];
  logic [DW-1:0] in_re [N];
  logic [DW-1:0] in_im [N];

  always #4 clk = ~clk;

  sfb_core #(.DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_idx(load_idx),
    .load_re(load_re), .load_im(load_im), .start(start), .rd_idx(rd_idx),
    .rd_re(rd_re), .rd_im(rd_im), .busy(busy), .done(done)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      n_fail = n_fail + 1;
      n_tests = n_tests + 1;
      $display("FAIL watchdog: run hung, got %0d cycles expected < 150000", cycles);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic check(input string req, input longint act, input longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [2*DW-1:0] ref_rot(input logic [DW-1:0] a,
                                              input logic [DW-1:0] b, input int k);
    case (k % 4)
      1:       return {b, DW'(-a)};
      2:       return {DW'(-a), DW'(-b)};
      3:       return {DW'(-b), a};
      default: return {a, b};
    endcase
  endfunction

  function automatic int ref_tw(input int s, input int k);
    if (s == 1) return k % 4;
    if (s == 2) return (k % 4) ^ (k / 4);
    return 0;
  endfunction

  function automatic int ref_rev(input int i);
    return ((i % 4) * 16) + (((i / 4) % 4) * 4) + (i / 16);
  endfunction

  // fully unrolled model: three stages of sixteen groups (R4 R5 R6 R7)
  task automatic run_model();
    logic [DW-1:0] xr [4];
    logic [DW-1:0] xi [4];
    logic [DW-1:0] tr [N];
    logic [DW-1:0] ti [N];
    logic [DW-1:0] ar, ai, pr, pi;
    for (int i = 0; i < N; i++) begin m_re[i] = in_re[i]; m_im[i] = in_im[i]; end
    for (int s = 0; s < 3; s++) begin
      for (int k = 0; k < 16; k++) begin
        for (int n = 0; n < 4; n++)
          {xr[n], xi[n]} = ref_rot(m_re[4*k+n], m_im[4*k+n], n * ref_tw(s, k));
        for (int m = 0; m < 4; m++) begin
          ar = '0; ai = '0;
          for (int n = 0; n < 4; n++) begin
            {pr, pi} = ref_rot(xr[n], xi[n], m * n);
            ar = ar + pr; ai = ai + pi;
          end
          m_re[4*k+m] = ar; m_im[4*k+m] = ai;
        end
        if (k == 15) begin
          for (int i = 0; i < N; i++) begin tr[i] = m_re[i]; ti[i] = m_im[i]; end
          for (int i = 0; i < N; i++) begin
            m_re[i] = tr[ref_rev(i)]; m_im[i] = ti[ref_rev(i)];
          end
        end
      end
    end
  endtask

  task automatic load_one(input int idx, input logic [DW-1:0] r, input logic [DW-1:0] im);
    load_en = 1'b1; load_idx = 6'(idx); load_re = r; load_im = im;
    @(posedge clk); @(negedge clk);
    load_en = 1'b0;
  endtask

  task automatic run_block(input string tag, input bit disturb);
    int cyc;
    int bad;
    for (int i = 0; i < N; i++) load_one(i, in_re[i], in_im[i]);
    check("R3 done cleared by load", done, 0);
    run_model();
    start = 1'b1;
    @(posedge clk); @(negedge clk);
    start = 1'b0;
    check("R3 busy after start", busy, 1);
    cyc = 0;
    while (!done && cyc < 100) begin
      @(posedge clk); @(negedge clk);
      cyc++;
      if (disturb && cyc == 10) begin
        load_en = 1'b1; load_idx = 6'd5; load_re = '1; load_im = '1; start = 1'b1;
      end
      if (disturb && cyc == 11) begin load_en = 1'b0; start = 1'b0; end
    end
    check("R3 micro-step cycles", cyc, 48);
    check("R3 busy low at done", busy, 0);
    bad = 0;
    for (int i = 0; i < N; i++) begin
      rd_idx = 6'(i); #1;
      if (rd_re != m_re[i] || rd_im != m_im[i]) begin
        if (bad == 0)
          $display("FAIL %s R4/R5/R6/R7 elem %0d: actual (%0d,%0d) expected (%0d,%0d)",
                   tag, i, rd_re, rd_im, m_re[i], m_im[i]);
        bad++;
      end
    end
    n_tests++;
    if (bad != 0) n_fail++;
    repeat (3) @(negedge clk);
    check("R3 done held while idle", done, 1);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; load_en = 1'b0; start = 1'b0;
    load_idx = '0; load_re = '0; load_im = '0; rd_idx = '0;
    repeat (3) @(negedge clk);
    check("R1 busy in reset", busy, 0);
    check("R1 done in reset", done, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 busy after reset", busy, 0);
    check("R1 done after reset", done, 0);

    // R2 load and read back
    load_one(63, 6'd17, 6'd42);
    load_one(0, 6'd33, 6'd1);
    rd_idx = 6'd63; #1;
    check("R2 readback re[63]", rd_re, 17);
    check("R2 readback im[63]", rd_im, 42);
    rd_idx = 6'd0; #1;
    check("R2 readback re[0]", rd_re, 33);

    // directed: zero block
    for (int i = 0; i < N; i++) begin in_re[i] = '0; in_im[i] = '0; end
    run_block("zero", 1'b0);
    // directed: impulse at element 0
    in_re[0] = 6'd1;
    run_block("impulse", 1'b0);
    // directed: impulse inside a later group, imaginary only
    in_re[0] = '0; in_im[22] = 6'd3;
    run_block("impulse22", 1'b0);
    // directed: all-ones extreme values
    for (int i = 0; i < N; i++) begin in_re[i] = '1; in_im[i] = 6'h20; end
    run_block("extreme", 1'b0);
    // random blocks, back to back (R9 counter reuse)
    for (int b = 0; b < 4; b++) begin
      for (int i = 0; i < N; i++) begin
        in_re[i] = DW'($urandom); in_im[i] = DW'($urandom);
      end
      run_block("R9 random", 1'b0);
    end
    // R8: load and start pulses while busy must not disturb
    for (int i = 0; i < N; i++) begin
      in_re[i] = DW'($urandom); in_im[i] = DW'($urandom);
    end
    run_block("R8 disturbed", 1'b1);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule